// File: doc/BRIEF.md
# Counter Peripheral with Latched Interrupt Flags

This block is a small peripheral that sits behind an AXI4-Lite slave port. It contains a free-running up-counter, which software can enable, stop and preload, and a vector of sticky event flags. The counter's wrap from its largest value back to zero produces a one-clock pulse. That pulse is brought out on a port and also sets flag bit 0. The remaining flag bits are set by one-clock event pulses from neighbouring logic. Any flag that is set raises the interrupt request line. That line is meant to drive a processor's single interrupt input.

A flag stays set until software acknowledges it. Each flag has a clear line. The clear lines are the low bits of an ordinary read/write register, so they are levels and not self-clearing strobes. To acknowledge a flag, the interrupt handler writes a 1 to the flag's clear bit and then writes a 0. While a clear bit is held at 1, the matching flag is forced low and any event for that flag is discarded.

Top module: `irq_counter_axil`

## Requirements
- R1: After the active-low synchronous reset `aresetn`, all four registers read zero, the counter holds zero, and `flag_o`, `irq_o` and `roll_o` are low.
- R2: Every write receives `bresp` = 2'b00 (OKAY) and every read receives `rresp` = 2'b00. A write changes only the byte lanes whose `wstrb` bit is 1. The auxiliary register at byte offset 0x8 is a plain 32-bit read/write register.
- R3: A write to offset 0x4 stores the preload value (low CNT_W bits) without changing the counter. A read of offset 0x4 returns the live counter value, zero-extended.
- R4: The control register is at offset 0x0. Bit 0 enables counting. Bit 1 is a level load: while it is 1, the counter is set to the preload value on every clock, even if bit 0 is also 1. While both bits are 0, the counter holds its value.
- R5: An enabled counter counts up by one per clock and wraps from 2^CNT_W-1 to 0. `roll_o` is high for exactly the one clock that follows the wrap edge.
- R6: Flag bit 0 becomes 1 on the clock after `roll_o` is high, and it stays 1 until it is cleared. `irq_o` is 1 exactly when any flag bit is 1.
- R7: Each clock, the flags take the value (flags OR set) AND NOT clear, bitwise. The clear vector is the low FLAG_W bits of the register at offset 0xC, with bit 0 clearing the rollover flag. Writing 1 to a clear bit clears its flag; writing 0 afterwards leaves the flag at 0.
- R8: When a set event and a held clear bit apply to the same flag in the same cycle, the clear wins. An event that arrives while its clear bit is held is lost, even after the clear bit is released.
- R9: `evt_i[i]` sets flag bit i+1. Clearing one flag bit leaves the other flag bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Synchronous reset, active low |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| evt_i | input | FLAG_W-1 | One-clock event pulses that set flag bits 1 and up |
| roll_o | output | 1 | Counter wrap pulse |
| flag_o | output | FLAG_W | Latched event flags |
| irq_o | output | 1 | Interrupt request, OR of all flags |

## Verification
The flag logic is tested with three patterns. In the first, a rollover occurs with its clear bit low, which shows that the flag latches and holds. In the second, a rollover and an external pulse each occur while their clear bits are held, which shows that the clear wins over a simultaneous set and that the event stays lost after the clear is released. In the third, two flags are set and only one is acknowledged, which shows that the clear bits act on single flags. The counter is tested three ways: preloaded while stopped, with load and enable both set, and run across the wrap. These runs separate the live readback from the stored preload value and confirm that the rollover pulse lasts one clock. Partial-strobe writes to the auxiliary register confirm that each byte lane is written independently.

// File: rtl/irq_cnt_pkg.sv
package irq_cnt_pkg;

    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    // word indices of the four registers
    localparam logic [1:0] IDX_CTRL = 2'd0;
    localparam logic [1:0] IDX_CNT  = 2'd1;
    localparam logic [1:0] IDX_AUX  = 2'd2;
    localparam logic [1:0] IDX_CLR  = 2'd3;

    // control register bit positions
    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_LD_BIT = 1;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    // merge new data into old data, one byte lane per strobe bit
    function automatic logic [DATA_W-1:0] merge_bytes(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [STRB_W-1:0] strb
    );
        logic [DATA_W-1:0] res;
        res = old_v;
        for (int b = 0; b < STRB_W; b++) begin
            if (strb[b]) res[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/icnt_axil_regs.sv
module icnt_axil_regs
    import irq_cnt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  awaddr,
    input  logic               awvalid,
    output logic               awready,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [STRB_W-1:0]  wstrb,
    input  logic               wvalid,
    output logic               wready,
    output logic [1:0]         bresp,
    output logic               bvalid,
    input  logic               bready,
    input  logic [ADDR_W-1:0]  araddr,
    input  logic               arvalid,
    output logic               arready,
    output logic [DATA_W-1:0]  rdata,
    output logic [1:0]         rresp,
    output logic               rvalid,
    input  logic               rready,
    input  logic [CNT_W-1:0]   cnt_val,
    output logic               run_en,
    output logic               load_en,
    output logic [CNT_W-1:0]   load_val,
    output logic [DATA_W-1:0]  clr_word
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [CNT_W-1:0]  preload;
        logic [DATA_W-1:0] aux;
        logic [DATA_W-1:0] clr;
        logic              bvalid;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } rf_t;

    rf_t rf_d, rf_q;

    logic              wr_go, rd_go;
    logic [1:0]        wr_idx, rd_idx;
    logic [DATA_W-1:0] cnt_ext;
    logic [DATA_W-1:0] pre_ext;
    logic [DATA_W-1:0] pre_new;
    logic              unused_addr_bits;

    assign wr_idx = awaddr[3:2];
    assign rd_idx = araddr[3:2];
    assign unused_addr_bits = &{1'b0, awaddr, araddr};

    always_comb begin
        cnt_ext = '0;
        cnt_ext[CNT_W-1:0] = cnt_val;
        pre_ext = '0;
        pre_ext[CNT_W-1:0] = rf_q.preload;
    end

    assign pre_new = merge_bytes(pre_ext, wdata, wstrb);

    assign wr_go = awvalid && wvalid && !rf_q.bvalid;
    assign rd_go = arvalid && !rf_q.rvalid;

    always_comb begin
        rf_d = rf_q;
        if (rf_q.bvalid && bready) rf_d.bvalid = 1'b0;
        if (rf_q.rvalid && rready) rf_d.rvalid = 1'b0;

        if (wr_go) begin
            unique case (wr_idx)
                IDX_CTRL: rf_d.ctrl    = merge_bytes(rf_q.ctrl, wdata, wstrb);
                IDX_CNT:  rf_d.preload = pre_new[CNT_W-1:0];
                IDX_AUX:  rf_d.aux     = merge_bytes(rf_q.aux, wdata, wstrb);
                default:  rf_d.clr     = merge_bytes(rf_q.clr, wdata, wstrb);
            endcase
            rf_d.bvalid = 1'b1;
        end

        if (rd_go) begin
            unique case (rd_idx)
                IDX_CTRL: rf_d.rdata = rf_q.ctrl;
                IDX_CNT:  rf_d.rdata = cnt_ext;
                IDX_AUX:  rf_d.rdata = rf_q.aux;
                default:  rf_d.rdata = rf_q.clr;
            endcase
            rf_d.rvalid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign awready  = wr_go;
    assign wready   = wr_go;
    assign bvalid   = rf_q.bvalid;
    assign bresp    = RESP_OKAY;
    assign arready  = rd_go;
    assign rvalid   = rf_q.rvalid;
    assign rdata    = rf_q.rdata;
    assign rresp    = RESP_OKAY;
    assign run_en   = rf_q.ctrl[CTRL_EN_BIT];
    assign load_en  = rf_q.ctrl[CTRL_LD_BIT];
    assign load_val = rf_q.preload;
    assign clr_word = rf_q.clr;

endmodule

// File: rtl/icnt_counter.sv
module icnt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             roll
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             roll;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.roll = 1'b0;
        if (load_en) begin
            st_d.cnt = load_val;
        end else if (run_en) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.cnt  = '0;
                st_d.roll = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign roll  = st_q.roll;

endmodule

// File: rtl/icnt_flags.sv
module icnt_flags #(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_vec,
    input  logic [FLAG_W-1:0] clr_vec,
    output logic [FLAG_W-1:0] flags
);

    logic [FLAG_W-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = (flag_q | set_vec) & ~clr_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags = flag_q;

endmodule

// File: rtl/irq_counter_axil.sv
module irq_counter_axil
    import irq_cnt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 8,
    parameter int FLAG_W = 8
) (
    input  logic              aclk,
    input  logic              aresetn,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic [FLAG_W-2:0] evt_i,
    output logic              roll_o,
    output logic [FLAG_W-1:0] flag_o,
    output logic              irq_o
);

    logic              run_en, load_en;
    logic [CNT_W-1:0]  load_val, count;
    logic [DATA_W-1:0] clr_word;
    logic [FLAG_W-1:0] clr_vec, set_vec;
    logic              roll;

    icnt_axil_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk      (aclk),
        .rst_n    (aresetn),
        .awaddr   (s_awaddr),
        .awvalid  (s_awvalid),
        .awready  (s_awready),
        .wdata    (s_wdata),
        .wstrb    (s_wstrb),
        .wvalid   (s_wvalid),
        .wready   (s_wready),
        .bresp    (s_bresp),
        .bvalid   (s_bvalid),
        .bready   (s_bready),
        .araddr   (s_araddr),
        .arvalid  (s_arvalid),
        .arready  (s_arready),
        .rdata    (s_rdata),
        .rresp    (s_rresp),
        .rvalid   (s_rvalid),
        .rready   (s_rready),
        .cnt_val  (count),
        .run_en   (run_en),
        .load_en  (load_en),
        .load_val (load_val),
        .clr_word (clr_word)
    );

    icnt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (aclk),
        .rst_n    (aresetn),
        .run_en   (run_en),
        .load_en  (load_en),
        .load_val (load_val),
        .count    (count),
        .roll     (roll)
    );

    assign clr_vec = clr_word[FLAG_W-1:0];
    assign set_vec = {evt_i, roll};

    icnt_flags #(.FLAG_W(FLAG_W)) u_flags (
        .clk     (aclk),
        .rst_n   (aresetn),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flag_o)
    );

    assign roll_o = roll;
    assign irq_o  = |flag_o;

endmodule

// File: rtl/irq_counter_axil_chk.sv
module irq_counter_axil_chk #(
    parameter int FLAG_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              roll,
    input logic [FLAG_W-1:0] flag,
    input logic [FLAG_W-1:0] clr,
    input logic              irq,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              rvalid,
    input logic              rready,
    input logic [1:0]        rresp
);

    a_r5_roll_single: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> !roll);

    a_r6_roll_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (roll && !clr[0]) |=> flag[0]);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[0] && !clr[0]) |=> flag[0]);

    a_r6_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[0]) |-> irq);

    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr[0] |=> !flag[0]);

    a_r2_bresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (bresp == 2'b00));

    a_r2_rresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rresp == 2'b00));

    a_r2_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    a_r2_rvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> rvalid);

endmodule

bind irq_counter_axil irq_counter_axil_chk #(.FLAG_W(FLAG_W)) u_chk (
    .clk    (aclk),
    .rst_n  (aresetn),
    .roll   (roll_o),
    .flag   (flag_o),
    .clr    (clr_vec),
    .irq    (irq_o),
    .bvalid (s_bvalid),
    .bready (s_bready),
    .bresp  (s_bresp),
    .rvalid (s_rvalid),
    .rready (s_rready),
    .rresp  (s_rresp)
);

// File: tb/irq_counter_axil_tb.sv
`timescale 1ns/1ps
module irq_counter_axil_tb;

    localparam int ADDR_W = 4;
    localparam int CNT_W  = 8;
    localparam int FLAG_W = 8;
    localparam logic [31:0] CMAX = 32'd255;

    logic              aclk = 1'b0;
    logic              aresetn = 1'b0;
    logic [ADDR_W-1:0] s_awaddr = '0;
    logic              s_awvalid = 1'b0;
    logic              s_awready;
    logic [31:0]       s_wdata = '0;
    logic [3:0]        s_wstrb = '0;
    logic              s_wvalid = 1'b0;
    logic              s_wready;
    logic [1:0]        s_bresp;
    logic              s_bvalid;
    logic              s_bready = 1'b0;
    logic [ADDR_W-1:0] s_araddr = '0;
    logic              s_arvalid = 1'b0;
    logic              s_arready;
    logic [31:0]       s_rdata;
    logic [1:0]        s_rresp;
    logic              s_rvalid;
    logic              s_rready = 1'b0;
    logic [FLAG_W-2:0] evt_i = '0;
    logic              roll_o;
    logic [FLAG_W-1:0] flag_o;
    logic              irq_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic done = 1'b0;

    always #2 aclk = ~aclk;

    irq_counter_axil #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_dut (
        .aclk(aclk), .aresetn(aresetn),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .evt_i(evt_i), .roll_o(roll_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge aclk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected finish earlier", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic axi_wr(input logic [3:0] addr, input logic [31:0] data,
                          input logic [3:0] strb, output logic [1:0] resp);
        logic hs;
        @(negedge aclk);
        s_awaddr = addr; s_awvalid = 1'b1;
        s_wdata = data; s_wstrb = strb; s_wvalid = 1'b1;
        hs = 1'b0;
        while (!hs) begin
            #1 hs = s_awready && s_wready;
            @(posedge aclk);
        end
        @(negedge aclk);
        s_awvalid = 1'b0; s_wvalid = 1'b0; s_bready = 1'b1;
        while (!s_bvalid) @(negedge aclk);
        resp = s_bresp;
        @(posedge aclk);
        @(negedge aclk);
        s_bready = 1'b0;
    endtask

    task automatic wr(input logic [3:0] addr, input logic [31:0] data);
        logic [1:0] r;
        axi_wr(addr, data, 4'hF, r);
    endtask

    task automatic axi_rd(input logic [3:0] addr, output logic [31:0] data,
                          output logic [1:0] resp);
        logic hs;
        @(negedge aclk);
        s_araddr = addr; s_arvalid = 1'b1;
        hs = 1'b0;
        while (!hs) begin
            #1 hs = s_arready;
            @(posedge aclk);
        end
        @(negedge aclk);
        s_arvalid = 1'b0; s_rready = 1'b1;
        while (!s_rvalid) @(negedge aclk);
        data = s_rdata; resp = s_rresp;
        @(posedge aclk);
        @(negedge aclk);
        s_rready = 1'b0;
    endtask

    function automatic logic [31:0] rd_only(input logic [31:0] d);
        return d;
    endfunction

    task automatic wait_roll(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge aclk);
            if (roll_o) seen = 1'b1;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d; logic [1:0] r;
        check("R1 flag_o", 32'(flag_o), 0);
        check("R1 irq_o", 32'(irq_o), 0);
        check("R1 roll_o", 32'(roll_o), 0);
        for (int a = 0; a < 4; a++) begin
            axi_rd(4'(a * 4), d, r);
            check("R1 register zero", d, 0);
        end
    endtask

    task automatic t_aux_strobe();
        logic [31:0] d; logic [1:0] r;
        axi_wr(4'h8, 32'hAABBCCDD, 4'hF, r);
        check("R2 bresp OKAY", 32'(r), 0);
        axi_wr(4'h8, 32'h11223344, 4'b0010, r);
        axi_rd(4'h8, d, r);
        check("R2 strobe merge", d, 32'hAABB33DD);
        check("R2 rresp OKAY", 32'(r), 0);
        axi_wr(4'h8, 32'h55667788, 4'b1001, r);
        axi_rd(4'h8, d, r);
        check("R2 two lanes", d, 32'h55BB3388);
    endtask

    task automatic t_load();
        logic [31:0] d; logic [1:0] r;
        wr(4'h4, 32'h10);
        axi_rd(4'h4, d, r);
        check("R3 preload write leaves counter", d, 0);
        wr(4'h0, 32'h2);
        wr(4'h0, 32'h0);
        axi_rd(4'h4, d, r);
        check("R4 load applied", d, 32'h10);
        repeat (10) @(negedge aclk);
        axi_rd(4'h4, d, r);
        check("R4 stopped counter holds", d, 32'h10);
        wr(4'h4, 32'h40);
        wr(4'h0, 32'h3);
        repeat (10) @(negedge aclk);
        axi_rd(4'h4, d, r);
        check("R4 load wins over enable", d, 32'h40);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_roll_latch();
        logic [31:0] d; logic [1:0] r; logic seen;
        wr(4'h4, CMAX - 32'd20);
        wr(4'h0, 32'h2);
        wr(4'h0, 32'h1);
        wait_roll(seen);
        check("R5 rollover pulse seen", 32'(seen), 1);
        @(negedge aclk);
        check("R5 roll one clock", 32'(roll_o), 0);
        check("R6 flag bit0 set", 32'(flag_o), 32'h1);
        check("R6 irq raised", 32'(irq_o), 1);
        wr(4'h0, 32'h0);
        axi_rd(4'h4, d, r);
        check("R5 wrapped to small value", 32'(d < 32'd16), 1);
        repeat (20) @(negedge aclk);
        check("R6 flag holds", 32'(flag_o[0]), 1);
        wr(4'hC, 32'h1);
        check("R7 clear drops flag", 32'(flag_o[0]), 0);
        check("R7 irq drops", 32'(irq_o), 0);
        wr(4'hC, 32'h0);
        repeat (3) @(negedge aclk);
        check("R7 flag stays clear after release", 32'(flag_o[0]), 0);
    endtask

    task automatic t_clear_priority();
        logic seen;
        wr(4'h4, CMAX - 32'd20);
        wr(4'h0, 32'h2);
        wr(4'hC, 32'h3);
        wr(4'h0, 32'h1);
        wait_roll(seen);
        check("R8 roll occurs under clear", 32'(seen), 1);
        @(negedge aclk);
        check("R8 clear wins over rollover", 32'(flag_o[0]), 0);
        evt_i[0] = 1'b1;
        @(negedge aclk);
        evt_i[0] = 1'b0;
        @(negedge aclk);
        check("R8 clear wins over event", 32'(flag_o[1]), 0);
        wr(4'h0, 32'h0);
        wr(4'hC, 32'h0);
        repeat (3) @(negedge aclk);
        check("R8 lost events stay lost", 32'(flag_o), 0);
        check("R8 irq low", 32'(irq_o), 0);
    endtask

    task automatic t_events();
        evt_i = 7'b0000010;
        @(negedge aclk);
        evt_i = 7'b0000001;
        @(negedge aclk);
        evt_i = '0;
        @(negedge aclk);
        check("R9 event flags set", 32'(flag_o), 32'h6);
        check("R9 irq from event", 32'(irq_o), 1);
        wr(4'hC, 32'h4);
        wr(4'hC, 32'h0);
        check("R9 only bit2 cleared", 32'(flag_o), 32'h2);
        wr(4'hC, 32'h2);
        wr(4'hC, 32'h0);
        check("R9 all cleared", 32'(flag_o), 0);
        check("R6 irq low when no flag", 32'(irq_o), 0);
    endtask

    initial begin
        repeat (4) @(negedge aclk);
        aresetn = 1'b1;
        @(negedge aclk);
        t_reset();
        t_aux_strobe();
        t_load();
        t_roll_latch();
        t_clear_priority();
        t_events();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule